// File: doc/BRIEF.md
# Rendezvous DMA Serial Link Engine

This block is one end of a point-to-point serial link between two processors. It has one wire out and one wire in, and it carries traffic in both directions. Each direction is run by a DMA channel. Software arms a channel by writing a start address and then a byte count into small memory-mapped registers. The armed channel then runs on its own. The sending channel fetches bytes from local memory and puts them on the outgoing wire. The receiving channel stores bytes from the incoming wire straight into local memory.

No message queue sits between the two memories. The sender keeps a byte on the line only until the far end acknowledges it, and it does not fetch the next byte before that acknowledge arrives. The receiver holds one arriving byte in its deserialiser until its own channel is armed. Only after that byte has been written to memory does it return an acknowledge. A transfer therefore moves only once both ends are armed, and this is the rendezvous a blocked task waits on. When a channel has moved its whole message it raises a one-cycle done pulse, which is used to wake the task.

Line coding is not return-to-zero, and the line idles low. Every bit lasts `BIT_CYC` clock cycles. A data frame is a start 1, a flag 1, eight data bits sent LSB first, and a stop 0. An acknowledge frame is a start 1 followed by a flag 0.

Memory traffic uses valid/ready streams, and both streams follow the same back-pressure rule. Once the engine raises `rd_req_valid` or `wr_valid`, it keeps that signal high, with address and data unchanged, until the matching ready is sampled high on a rising clock edge. Memory answers each accepted read request with exactly one `rd_rsp_valid` pulse, at least one cycle after the request was accepted. That pulse has no ready, and the engine always takes it.

Top module: `lnk_engine`

## Requirements
- R1: While reset is held, `link_tx`, `rd_req_valid`, `wr_valid`, `out_done` and `in_done` are all 0.
- R2: `reg_sel` picks the register that a write to `reg_wdata` lands in:
  - 0: send start address.
  - 1: send length, which also arms the send channel.
  - 2: receive start address.
  - 3: receive length, which also arms the receive channel.

  Writes to a channel's registers while that channel is armed are ignored.
- R3: The line idles at 0. Each bit is held for exactly `BIT_CYC` cycles. A data frame is 1, 1, d0..d7, 0 and an acknowledge frame is 1, 0.
- R4: The send channel reads addresses start, start+1, and so on, and transmits each byte it reads. It issues no read for byte k+1 until the acknowledge for byte k has arrived.
- R5: `out_done` pulses for one cycle after the acknowledge of the last byte, and never earlier.
- R6: Writing a length of 0 makes the channel's done signal high in the cycle right after the write. No frame is sent and no memory access is made.
- R7: Each received data frame is written to the receive address, and that address then increments. After each write is accepted, an acknowledge frame is sent on `link_tx`.
- R8: A data frame that arrives while the receive channel is not armed is held. It is neither written nor acknowledged until the channel is armed.
- R9: `in_done` pulses for one cycle when the last byte of the receive message has been accepted by memory, and never earlier.
- R10: An unaccepted `rd_req_valid` or `wr_valid` stays high with its address (and data) stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (see R2) |
| reg_wdata | input | ADDR_W | Register write value |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory read request ready |
| rd_req_addr | output | ADDR_W | Read byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 8 | Read data byte |
| wr_valid | output | 1 | Memory write valid |
| wr_ready | input | 1 | Memory write ready |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | 8 | Write data byte |
| link_rx | input | 1 | Incoming serial wire |
| link_tx | output | 1 | Outgoing serial wire |
| out_done | output | 1 | Send message complete pulse |
| in_done | output | 1 | Receive message complete pulse |

## Verification
The properties assume that `link_rx` is already synchronous to `clk`. They also assume that the far end keeps to the protocol: it sends a new data frame only after it has seen the acknowledge for the previous one, and it produces well-formed frames. The bench's partner model drives `link_rx` only at falling edges, with whole bits that each last `BIT_CYC` cycles. It waits for each decoded acknowledge before it sends more data. The memory model returns a read response only in the cycle after a request is accepted. Ready patterns that stall on some cycles exercise the stability rules without ever breaking the one-response-per-request contract.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
  localparam logic [1:0] SEL_OUT_ADDR = 2'd0;
  localparam logic [1:0] SEL_OUT_LEN  = 2'd1;
  localparam logic [1:0] SEL_IN_ADDR  = 2'd2;
  localparam logic [1:0] SEL_IN_LEN   = 2'd3;
  localparam int DATA_FRAME_BITS = 11;
  localparam int ACK_FRAME_BITS  = 2;
  typedef enum logic [2:0] {
    O_IDLE, O_REQ, O_RSP, O_SEND, O_WACK
  } out_st_t;
endpackage

// File: rtl/lnk_ser.sv
module lnk_ser #(
  parameter int BIT_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ack_req,
  input  logic       dat_req,
  input  logic [7:0] dat_byte,
  output logic       dat_take,
  output logic       tx
);
  import lnk_pkg::*;
  localparam int CW = $clog2(BIT_CYC);
  localparam int FB = DATA_FRAME_BITS;

  logic          busy, ack_pend;
  logic [FB-1:0] shreg;
  logic [3:0]    nbits;
  logic [CW-1:0] cyc;
  logic          start_ack;

  assign start_ack = !busy && ack_pend;
  assign dat_take  = !busy && !ack_pend && dat_req;
  assign tx        = busy & shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      ack_pend <= 1'b0;
      shreg    <= '0;
      nbits    <= '0;
      cyc      <= '0;
    end else begin
      if (start_ack) begin
        // acknowledge wins over data so the partner is never stalled behind us
        shreg    <= FB'(2'b01);
        nbits    <= 4'(ACK_FRAME_BITS);
        cyc      <= CW'(BIT_CYC - 1);
        busy     <= 1'b1;
        ack_pend <= 1'b0;
      end else if (dat_take) begin
        shreg <= {1'b0, dat_byte, 2'b11};
        nbits <= 4'(FB);
        cyc   <= CW'(BIT_CYC - 1);
        busy  <= 1'b1;
      end else if (busy) begin
        if (cyc != '0) begin
          cyc <= cyc - CW'(1);
        end else if (nbits == 4'd1) begin
          busy <= 1'b0;
        end else begin
          shreg <= {1'b0, shreg[FB-1:1]};
          nbits <= nbits - 4'd1;
          cyc   <= CW'(BIT_CYC - 1);
        end
      end
      if (ack_req) ack_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/lnk_des.sv
module lnk_des #(
  parameter int BIT_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx,
  output logic       ack_seen,
  output logic       byte_vld,
  output logic [7:0] byte_q
);
  localparam int FIRST = BIT_CYC + BIT_CYC / 2 - 1;
  localparam int CW    = $clog2(FIRST + 1);

  logic          rx_q, active;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q     <= 1'b0;
      active   <= 1'b0;
      cnt      <= '0;
      idx      <= '0;
      byte_q   <= '0;
      ack_seen <= 1'b0;
      byte_vld <= 1'b0;
    end else begin
      rx_q     <= rx;
      ack_seen <= 1'b0;
      byte_vld <= 1'b0;
      if (!active) begin
        if (rx && !rx_q) begin
          active <= 1'b1;
          cnt    <= CW'(FIRST);
          idx    <= '0;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - CW'(1);
      end else begin
        cnt <= CW'(BIT_CYC - 1);
        if (idx == 4'd0) begin
          if (!rx) begin
            ack_seen <= 1'b1;
            active   <= 1'b0;
          end else begin
            idx <= 4'd1;
          end
        end else if (idx == 4'd9) begin
          byte_vld <= 1'b1;
          active   <= 1'b0;
        end else begin
          byte_q <= {rx, byte_q[7:1]};
          idx    <= idx + 4'd1;
        end
      end
    end
  end
endmodule

// File: rtl/lnk_out_dma.sv
module lnk_out_dma #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [7:0]        rd_rsp_data,
  output logic              dat_req,
  output logic [7:0]        dat_byte,
  input  logic              dat_take,
  input  logic              ack_seen,
  output logic              done
);
  import lnk_pkg::*;
  out_st_t          st;
  logic [LEN_W-1:0] left;

  assign rd_req_valid = (st == O_REQ);
  assign dat_req      = (st == O_SEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= O_IDLE;
      left        <= '0;
      rd_req_addr <= '0;
      dat_byte    <= '0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        O_IDLE: if (reg_we) begin
          if (reg_sel == SEL_OUT_ADDR) rd_req_addr <= reg_wdata;
          if (reg_sel == SEL_OUT_LEN) begin
            if (reg_wdata[LEN_W-1:0] == '0) begin
              done <= 1'b1;
            end else begin
              left <= reg_wdata[LEN_W-1:0];
              st   <= O_REQ;
            end
          end
        end
        O_REQ:  if (rd_req_ready) st <= O_RSP;
        O_RSP:  if (rd_rsp_valid) begin
          dat_byte <= rd_rsp_data;
          st       <= O_SEND;
        end
        O_SEND: if (dat_take) st <= O_WACK;
        O_WACK: if (ack_seen) begin
          rd_req_addr <= rd_req_addr + ADDR_W'(1);
          left        <= left - LEN_W'(1);
          if (left == LEN_W'(1)) begin
            done <= 1'b1;
            st   <= O_IDLE;
          end else begin
            st <= O_REQ;
          end
        end
        default: st <= O_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lnk_in_dma.sv
module lnk_in_dma #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              byte_vld,
  input  logic [7:0]        byte_in,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              ack_req,
  output logic              done
);
  import lnk_pkg::*;
  logic             armed, full;
  logic [LEN_W-1:0] left;

  assign wr_valid = armed && full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      full    <= 1'b0;
      left    <= '0;
      wr_addr <= '0;
      wr_data <= '0;
      ack_req <= 1'b0;
      done    <= 1'b0;
    end else begin
      ack_req <= 1'b0;
      done    <= 1'b0;
      if (byte_vld && !full) begin
        wr_data <= byte_in;
        full    <= 1'b1;
      end
      if (!armed && reg_we) begin
        if (reg_sel == SEL_IN_ADDR) wr_addr <= reg_wdata;
        if (reg_sel == SEL_IN_LEN) begin
          if (reg_wdata[LEN_W-1:0] == '0) begin
            done <= 1'b1;
          end else begin
            left  <= reg_wdata[LEN_W-1:0];
            armed <= 1'b1;
          end
        end
      end
      if (wr_valid && wr_ready) begin
        full    <= 1'b0;
        wr_addr <= wr_addr + ADDR_W'(1);
        left    <= left - LEN_W'(1);
        ack_req <= 1'b1;
        if (left == LEN_W'(1)) begin
          armed <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lnk_engine.sv
module lnk_engine #(
  parameter int ADDR_W  = 16,
  parameter int LEN_W   = 16,
  parameter int BIT_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [7:0]        rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  input  logic              link_rx,
  output logic              link_tx,
  output logic              out_done,
  output logic              in_done
);
  logic       ack_req, dat_req, dat_take, ack_seen, byte_vld;
  logic [7:0] dat_byte, rx_byte;

  lnk_ser #(.BIT_CYC(BIT_CYC)) u_ser (
    .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .dat_req(dat_req),
    .dat_byte(dat_byte), .dat_take(dat_take), .tx(link_tx)
  );

  lnk_des #(.BIT_CYC(BIT_CYC)) u_des (
    .clk(clk), .rst_n(rst_n), .rx(link_rx), .ack_seen(ack_seen),
    .byte_vld(byte_vld), .byte_q(rx_byte)
  );

  lnk_out_dma #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_out (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .dat_req(dat_req), .dat_byte(dat_byte), .dat_take(dat_take),
    .ack_seen(ack_seen), .done(out_done)
  );

  lnk_in_dma #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_in (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .byte_vld(byte_vld), .byte_in(rx_byte),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .ack_req(ack_req), .done(in_done)
  );
endmodule

// File: rtl/lnk_engine_chk.sv
module lnk_engine_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              link_tx,
  input logic              out_done,
  input logic              in_done
);
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));
  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  // R5
  out_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done);
  // R9
  in_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_done |=> !in_done);
  // R3
  start_bit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_tx) |=> link_tx);
endmodule

bind lnk_engine lnk_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data), .link_tx(link_tx), .out_done(out_done), .in_done(in_done)
);

// File: tb/lnk_engine_tb_top.sv
module lnk_engine_tb_top;
  localparam int B = 4;
  localparam int AW = 16;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [1:0] reg_sel = 0;
  logic [AW-1:0] reg_wdata = 0;
  logic rd_req_valid, rd_req_ready = 0, rd_rsp_valid = 0;
  logic [AW-1:0] rd_req_addr, wr_addr;
  logic [7:0] rd_rsp_data = 0, wr_data;
  logic wr_valid, wr_ready = 0, link_rx = 0, link_tx, out_done, in_done;

  always #10 clk = ~clk;

  lnk_engine #(.ADDR_W(AW), .LEN_W(AW), .BIT_CYC(B)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .link_rx(link_rx), .link_tx(link_tx),
    .out_done(out_done), .in_done(in_done)
  );

  int nchk = 0, errs = 0, cyc = 0;
  bit fin = 0;
  // reference-model state
  int out_base = 0, out_len_exp = 0, acks_sent = 0, rd_fire_cnt = 0;
  int in_len_exp = 0, wr_cnt = 0, ack_cnt = 0, out_done_cnt = 0, in_done_cnt = 0;
  int wa_q[$], wd_q[$];
  logic [7:0] dq[$];
  bit pend_rd = 0, pend_wr = 0, rd_go = 0;
  logic [AW-1:0] pend_rd_addr, pend_wr_addr, rd_go_addr;
  logic [7:0] pend_wr_data;
  int dst = 0, dcnt = 0, didx = 0;
  logic dprev = 0, dbit = 0;
  logic [7:0] dsh = 0;

  function automatic int memb(input int a);
    return (a * 37 + 11) & 255;
  endfunction

  task automatic chk(input string r, input int a, input int e);
    nchk++;
    if (a != e) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", r, a, e);
    end
  endtask

  // per-clock reference model: memory, partner decoder, pulse rules
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (pend_rd) chk("R10 rd hold", int'(rd_req_valid && rd_req_addr == pend_rd_addr), 1);
      if (pend_wr) chk("R10 wr hold", int'(wr_valid && wr_addr == pend_wr_addr && wr_data == pend_wr_data), 1);
      rd_rsp_valid = rd_go;
      rd_rsp_data = 8'(memb(int'(rd_go_addr)));
      rd_go = 0;
      rd_req_ready = cyc[0];
      wr_ready = (cyc % 3) != 1;
      if (rd_req_valid && rd_req_ready) begin
        chk("R4 read before ack", int'(rd_fire_cnt <= acks_sent), 1);
        chk("R4 read address", int'(rd_req_addr), out_base + rd_fire_cnt);
        rd_go = 1; rd_go_addr = rd_req_addr; rd_fire_cnt++; pend_rd = 0;
      end else begin
        pend_rd = rd_req_valid; pend_rd_addr = rd_req_addr;
      end
      if (wr_valid && wr_ready) begin
        wa_q.push_back(int'(wr_addr)); wd_q.push_back(int'(wr_data)); wr_cnt++; pend_wr = 0;
      end else begin
        pend_wr = wr_valid; pend_wr_addr = wr_addr; pend_wr_data = wr_data;
      end
      if (out_done) begin
        out_done_cnt++;
        chk("R5 done after last ack", int'(acks_sent >= out_len_exp), 1);
      end
      if (in_done) begin
        in_done_cnt++;
        chk("R9 done after last write", int'(wr_cnt >= in_len_exp), 1);
      end
      if (dst == 0) begin
        if (link_tx && !dprev) begin dst = 1; dcnt = 0; dbit = 1; end
      end else begin
        dcnt++;
        if (dcnt % B == 0) begin
          didx = dcnt / B; dbit = link_tx;
          if (didx == 1 && !link_tx) begin ack_cnt++; dst = 0; end
          else if (didx >= 2 && didx <= 9) dsh = {link_tx, dsh[7:1]};
          else if (didx == 10) begin
            chk("R3 stop bit", int'(link_tx), 0);
            dq.push_back(dsh); dst = 0;
          end
        end else chk("R3 bit held", int'(link_tx), int'(dbit));
      end
      dprev = link_tx;
    end
  end

  task automatic reg_wr(input logic [1:0] s, input int v);
    @(negedge clk); reg_we = 1; reg_sel = s; reg_wdata = AW'(v);
    @(negedge clk); reg_we = 0;
  endtask

  task automatic send_bit(input logic v);
    link_rx = v; repeat (B) @(negedge clk);
  endtask

  task automatic send_ack();
    acks_sent++;
    send_bit(1); send_bit(0);
  endtask

  task automatic send_data(input logic [7:0] d);
    send_bit(1); send_bit(1);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    send_bit(0);
  endtask

  task automatic wait_byte();
    for (int t = 0; t < 800 && dq.size() == 0; t++) @(negedge clk);
  endtask

  task automatic wait_ack(input int n);
    for (int t = 0; t < 800 && ack_cnt < n; t++) @(negedge clk);
  endtask

  task automatic out_start(input int base, input int len);
    out_base = base; out_len_exp = len; acks_sent = 0; rd_fire_cnt = 0; out_done_cnt = 0;
    reg_wr(2'd0, base); reg_wr(2'd1, len);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 tx idle", int'(link_tx), 0);
    chk("R1 rd valid", int'(rd_req_valid), 0);
    chk("R1 wr valid", int'(wr_valid), 0);
    chk("R1 done pulses", int'(out_done | in_done), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R4 R5 R3: four-byte send, acks after varied delays
    out_start(16'h40, 4);
    for (int i = 0; i < 4; i++) begin
      wait_byte();
      chk("R4 byte arrived", dq.size(), 1);
      if (dq.size() > 0) chk("R4 byte value", int'(dq.pop_front()), memb(16'h40 + i));
      repeat (20 + 7 * i) @(negedge clk);
      chk("R4 no byte before ack", dq.size(), 0);
      send_ack();
    end
    for (int t = 0; t < 100 && out_done_cnt == 0; t++) @(negedge clk);
    repeat (30) @(negedge clk);
    chk("R5 single done", out_done_cnt, 1);

    // R2: register writes while armed are ignored
    out_start(16'h10, 2);
    wait_byte();
    if (dq.size() > 0) chk("R2 first byte", int'(dq.pop_front()), memb(16'h10));
    reg_wr(2'd0, 16'h99); reg_wr(2'd1, 7);
    send_ack();
    wait_byte();
    chk("R2 second byte present", dq.size(), 1);
    if (dq.size() > 0) chk("R2 second byte", int'(dq.pop_front()), memb(16'h11));
    send_ack();
    repeat (150) @(negedge clk);
    chk("R2 no extra bytes", dq.size(), 0);
    chk("R2 one done", out_done_cnt, 1);

    // R6: zero lengths
    out_start(16'h30, 0);
    chk("R6 out done at once", int'(out_done), 1);
    in_len_exp = 0;
    reg_wr(2'd2, 16'h30); reg_wr(2'd3, 0);
    chk("R6 in done at once", int'(in_done), 1);
    repeat (60) @(negedge clk);
    chk("R6 no reads", rd_fire_cnt, 0);
    chk("R6 no writes", wr_cnt, 0);
    chk("R6 no frames", dq.size() + ack_cnt, 0);

    // R8 R7 R9: byte before arming, then three-byte receive
    in_len_exp = 3; in_done_cnt = 0;
    send_data(8'hA5);
    repeat (60) @(negedge clk);
    chk("R8 held not written", wr_cnt, 0);
    chk("R8 held not acked", ack_cnt, 0);
    reg_wr(2'd2, 16'h80); reg_wr(2'd3, 3);
    wait_ack(1);
    chk("R7 ack 1", ack_cnt, 1);
    chk("R7 write 1 addr", wa_q.size() > 0 ? wa_q[0] : -1, 16'h80);
    chk("R7 write 1 data", wd_q.size() > 0 ? wd_q[0] : -1, 8'hA5);
    send_data(8'h3C);
    wait_ack(2);
    chk("R7 write 2 addr", wa_q.size() > 1 ? wa_q[1] : -1, 16'h81);
    chk("R7 write 2 data", wd_q.size() > 1 ? wd_q[1] : -1, 8'h3C);
    chk("R9 not done yet", in_done_cnt, 0);
    send_data(8'h5A);
    wait_ack(3);
    repeat (10) @(negedge clk);
    chk("R7 write 3 data", wd_q.size() > 2 ? wd_q[2] : -1, 8'h5A);
    chk("R9 done once", in_done_cnt, 1);

    // R8: byte after completion waits for re-arm
    send_data(8'h77);
    repeat (80) @(negedge clk);
    chk("R8 no write while disarmed", wr_cnt, 3);
    chk("R8 no ack while disarmed", ack_cnt, 3);
    in_len_exp = 4;
    reg_wr(2'd2, 16'h90); reg_wr(2'd3, 1);
    wait_ack(4);
    repeat (10) @(negedge clk);
    chk("R7 rearm addr", wa_q.size() > 3 ? wa_q[3] : -1, 16'h90);
    chk("R7 rearm data", wd_q.size() > 3 ? wd_q[3] : -1, 8'h77);
    chk("R9 second done", in_done_cnt, 2);

    fin = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, errs);
      $finish;
    end
  end
endmodule